// File: doc/BRIEF.md
# Interrupt Priority Control Register Bank

This block is a single 32-bit control register that sets up eight interrupt sources. Each source owns one 4-bit nibble of the word. The top bit of the nibble is a pending flag and the three bits below it hold a priority level. Software reads and writes the word through a synchronous port with one register select.

Each of the eight request inputs is tagged at build time as either external (edge-latched) or internal (level-followed). From the pending sources that are not inhibited, the block continuously reports the highest priority level and the index of the source that wins. Vectoring and acknowledge cycles are handled by the logic around it.

Priority fields are guarded. A write changes a source's level only when the same write also carries a 1 in that source's pending position. For external sources, that same 1 also clears the latched request.

Top module: `irq_prio_bank`

## Requirements
- R1: Source i owns bits [4i+3:4i] of the register. Bit 4i+3 reads back as its pending flag and bits [4i+2:4i] hold its level. The readback is `rdata_o` and is valid every cycle.
- R2: After reset every level is 000 and every pending flag is 0. Consequently `irq_lvl_o` and `irq_src_o` are 0.
- R3: A write takes effect only when `sel_i` and `wr_en_i` are both high at a rising edge. It loads a source's level only if the written data has a 1 in that source's pending bit. Otherwise the level keeps its value.
- R4: An external source (bit i of `EXT_MASK` set, default sources 0 to 3) latches when its request is sampled high at an edge after being sampled low at the previous edge, provided its level is non-zero. It reads as pending from the next cycle.
- R5: Writing a 1 to an external source's pending bit clears its latch. Writing a 0 leaves the latch unchanged.
- R6: After a clear, an external source latches again only on a fresh low-to-high transition. A clear and a rising edge at the same clock edge leave the latch clear.
- R7: An internal source reads as pending exactly when its request was sampled high at the previous edge and its level is non-zero. A register write cannot clear it.
- R8: A source with level 000 never reads as pending and never drives the output.
- R9: `irq_lvl_o` is the largest level among pending sources. `irq_src_o` is the index of that source, and the higher index wins ties. With nothing pending, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| wr_en_i | input | 1 | Write strobe, qualified by sel_i |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Register image: pending flag and level per nibble |
| req_i | input | 8 | Active-high interrupt requests, one per source |
| irq_lvl_o | output | 3 | Highest active priority level, 0 when none |
| irq_src_o | output | 3 | Index of the winning source |

## Verification
The hardest case to reach from the ports is a guarded clear landing on the very edge at which an external request rises, while that request is then held high. The stimulus aligns a clearing write with the first high sample of a request and keeps the request asserted for several cycles to show that no relatch occurs. A long random phase mixes request toggles with writes whose pending bits are random, so that clears, rising edges and level changes collide on the same source at the same edge many times. Ties between equal levels are set up directly, with sources in low and high nibbles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  parameter int unsigned IRQ_NSRC_DEF  = 8;
  parameter int unsigned IRQ_LVL_W_DEF = 3;

  function automatic int unsigned nib_base(int unsigned idx, int unsigned nib_w);
    return idx * nib_w;
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int unsigned LVL_W  = 3,
  parameter bit          IS_EXT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             touch_i,
  input  logic [LVL_W-1:0] lvl_wr_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             pend_o
);
  logic [LVL_W-1:0] lvl_q;
  logic             req_q;
  logic             pend_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (touch_i) lvl_q <= lvl_wr_i;
    end
  end

  if (IS_EXT) begin : g_ext
    logic latch_q;
    // clear beats a coincident edge; edge detect forces a fresh toggle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             latch_q <= 1'b0;
      else if (touch_i)                        latch_q <= 1'b0;
      else if (req_i && !req_q && (|lvl_q))    latch_q <= 1'b1;
    end
    assign pend_raw = latch_q;
  end else begin : g_int
    assign pend_raw = req_q;
  end

  assign lvl_o  = lvl_q;
  assign pend_o = pend_raw & (|lvl_q);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0]            lvl_o,
  output logic [SRC_W-1:0]            src_o
);
  always_comb begin
    lvl_o = '0;
    src_o = '0;
    // ascending scan with >= lets the higher index win ties
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (pend_i[i] && (lvl_i[i] >= lvl_o)) begin
        lvl_o = lvl_i[i];
        src_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned      N_SRC    = IRQ_NSRC_DEF,
  parameter int unsigned      LVL_W    = IRQ_LVL_W_DEF,
  parameter logic [N_SRC-1:0] EXT_MASK = 8'h0F,
  localparam int unsigned NIB_W  = LVL_W + 1,
  localparam int unsigned DATA_W = N_SRC * NIB_W,
  localparam int unsigned SRC_W  = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  req_i,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [SRC_W-1:0]  irq_src_o
);
  logic                       wr;
  logic [N_SRC-1:0]           pend;
  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [DATA_W-1:0]          img;

  assign wr = sel_i & wr_en_i;

  for (genvar g = 0; g < int'(N_SRC); g++) begin : g_slot
    localparam int unsigned BASE = nib_base(g, NIB_W);
    logic touch;
    assign touch = wr & wdata_i[BASE+LVL_W];

    irq_src_slot #(
      .LVL_W (LVL_W),
      .IS_EXT(EXT_MASK[g])
    ) slot_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i[g]),
      .touch_i (touch),
      .lvl_wr_i(wdata_i[BASE +: LVL_W]),
      .lvl_o   (lvl[g]),
      .pend_o  (pend[g])
    );

    assign img[BASE +: NIB_W] = {pend[g], lvl[g]};
  end

  irq_prio_arb #(
    .N_SRC(N_SRC),
    .LVL_W(LVL_W)
  ) arb_i (
    .pend_i(pend),
    .lvl_i (lvl),
    .lvl_o (irq_lvl_o),
    .src_o (irq_src_o)
  );

  assign rdata_o = img;
endmodule

// File: rtl/irq_prio_bank_chk.sv
module irq_prio_bank_chk #(
  parameter int unsigned      N_SRC    = 8,
  parameter int unsigned      LVL_W    = 3,
  parameter logic [N_SRC-1:0] EXT_MASK = 8'h0F,
  localparam int unsigned NIB_W  = LVL_W + 1,
  localparam int unsigned DATA_W = N_SRC * NIB_W,
  localparam int unsigned SRC_W  = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  req_i,
  input logic [DATA_W-1:0] img_i,
  input logic [LVL_W-1:0]  irq_lvl_o,
  input logic [SRC_W-1:0]  irq_src_o
);
  logic             any_pend;
  logic [LVL_W-1:0] win_lvl;
  logic             win_pend;

  always_comb begin
    any_pend = 1'b0;
    for (int i = 0; i < int'(N_SRC); i++) any_pend |= img_i[i*NIB_W+LVL_W];
    win_lvl  = img_i[int'(irq_src_o)*NIB_W +: LVL_W];
    win_pend = img_i[int'(irq_src_o)*NIB_W + LVL_W];
  end

  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_pend |-> (irq_lvl_o == '0 && irq_src_o == '0)); // R9
  AST_WIN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lvl_o != '0) |-> (win_pend && win_lvl == irq_lvl_o)); // R9

  for (genvar g = 0; g < int'(N_SRC); g++) begin : g_chk
    localparam int unsigned B = g * NIB_W;
    AST_LVL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && wr_en_i && !wdata_i[B+LVL_W]) |=> $stable(img_i[B +: LVL_W])); // R3
    AST_LVL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && wr_en_i && wdata_i[B+LVL_W]) |=> (img_i[B +: LVL_W] == $past(wdata_i[B +: LVL_W]))); // R3
    AST_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (img_i[B +: LVL_W] == '0) |-> !img_i[B+LVL_W]); // R8
    AST_NOT_BEATEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(img_i[B+LVL_W] && (img_i[B +: LVL_W] > irq_lvl_o))); // R9
    if (EXT_MASK[g]) begin : g_ext
      AST_EXT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_en_i && wdata_i[B+LVL_W]) |=> !img_i[B+LVL_W]); // R5
      AST_EXT_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(img_i[B+LVL_W]) |-> $past(req_i[g])); // R4
    end else begin : g_int
      AST_INT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        img_i[B+LVL_W] |-> $past(req_i[g])); // R7
    end
  end
endmodule

bind irq_prio_bank irq_prio_bank_chk #(
  .N_SRC   (N_SRC),
  .LVL_W   (LVL_W),
  .EXT_MASK(EXT_MASK)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_en_i  (wr_en_i),
  .wdata_i  (wdata_i),
  .req_i    (req_i),
  .img_i    (img),
  .irq_lvl_o(irq_lvl_o),
  .irq_src_o(irq_src_o)
);

// File: tb/irq_prio_bank_tb_top.sv
`timescale 1ns/1ps
module irq_prio_bank_tb_top;
  localparam logic [7:0] EXT = 8'h0F;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  req_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  irq_lvl_o;
  logic [2:0]  irq_src_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [2:0] m_lvl [8];
  bit         m_latch [8];
  bit         m_req [8];

  always #2 clk = ~clk;

  irq_prio_bank dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .req_i    (req_i),
    .irq_lvl_o(irq_lvl_o),
    .irq_src_o(irq_src_o)
  );

  function automatic bit exp_pend(int i);
    return (EXT[i] ? m_latch[i] : m_req[i]) && (m_lvl[i] != 3'd0);
  endfunction

  function automatic logic [31:0] exp_img();
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[i*4 +: 4] = {exp_pend(i), m_lvl[i]};
    return v;
  endfunction

  function automatic logic [5:0] exp_out();
    logic [2:0] bl = '0;
    logic [2:0] bs = '0;
    for (int i = 7; i >= 0; i--)
      if (exp_pend(i) && m_lvl[i] > bl) begin
        bl = m_lvl[i];
        bs = 3'(i);
      end
    return {bl, bs};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " readback"}, rdata_o, exp_img());
    chk({tag, " output"}, {26'd0, irq_lvl_o, irq_src_o}, {26'd0, exp_out()});
  endtask

  task automatic model_edge(logic [7:0] req, bit wr, logic [31:0] wd);
    for (int i = 0; i < 8; i++) begin
      bit clr = wr && wd[i*4+3];
      bit rise = req[i] && !m_req[i];
      if (EXT[i]) begin
        if (clr) m_latch[i] = 1'b0;
        else if (rise && m_lvl[i] != 3'd0) m_latch[i] = 1'b1;
      end
      if (clr) m_lvl[i] = wd[i*4 +: 3];
      m_req[i] = req[i];
    end
  endtask

  task automatic step(string tag, logic [7:0] req, bit sel, bit we, logic [31:0] wd);
    req_i = req; sel_i = sel; wr_en_i = we; wdata_i = wd;
    @(posedge clk);
    model_edge(req, sel && we, wd);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_lvl[i] = '0; m_latch[i] = 0; m_req[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 reset readback", rdata_o, 32'h0);
    chk("R2 reset output", {26'd0, irq_lvl_o, irq_src_o}, 32'h0);
    check_all("R2");

    // R1 nibble layout: source 5 level 2
    step("R1", 8'h00, 1, 1, 32'h00A0_0000);
    chk("R1 layout", rdata_o, 32'h0020_0000);
    // R3 guard and select gating
    step("R3 unguarded", 8'h00, 1, 1, 32'h0050_0000);
    chk("R3 level kept", rdata_o, 32'h0020_0000);
    step("R3 no select", 8'h00, 0, 1, 32'h00F0_0000);
    chk("R3 sel low", rdata_o, 32'h0020_0000);
    step("R3 no wr", 8'h00, 1, 0, 32'h00F0_0000);
    step("R3 src0 lvl3", 8'h00, 1, 1, 32'h0000_000B);
    // R4 external latch
    step("R4 rise", 8'h01, 0, 0, 0);
    chk("R4 latched", rdata_o, 32'h0020_000B);
    chk("R4 winner", {26'd0, irq_lvl_o, irq_src_o}, {26'd0, 3'd3, 3'd0});
    step("R4 hold", 8'h01, 0, 0, 0);
    // R5 write 0 keeps, write 1 clears
    step("R5 write zero", 8'h01, 1, 1, 32'h0000_0003);
    chk("R5 kept", rdata_o[3], 1);
    step("R5 clear", 8'h01, 1, 1, 32'h0000_000B);
    chk("R5 cleared", rdata_o[3], 0);
    // R6 held request does not relatch
    step("R6 held", 8'h01, 0, 0, 0);
    step("R6 held", 8'h01, 0, 0, 0);
    chk("R6 no relatch", rdata_o[3], 0);
    step("R6 release", 8'h00, 0, 0, 0);
    step("R6 retoggle", 8'h01, 0, 0, 0);
    chk("R6 relatched", rdata_o[3], 1);
    // R6 clear coincident with rise
    step("R6 low", 8'h00, 1, 1, 32'h0000_000B);
    step("R6 clear+rise", 8'h01, 1, 1, 32'h0000_000B);
    chk("R6 clear wins", rdata_o[3], 0);
    step("R6 held after", 8'h01, 0, 0, 0);
    chk("R6 still clear", rdata_o[3], 0);
    step("R6 low", 8'h00, 0, 0, 0);
    step("R6 rise", 8'h01, 0, 0, 0);
    chk("R6 latch again", rdata_o[3], 1);
    // R7 internal follows request
    step("R7 req", 8'h21, 0, 0, 0);
    chk("R7 pending", rdata_o[23], 1);
    step("R7 write one", 8'h21, 1, 1, 32'h00A0_0000);
    chk("R7 not cleared", rdata_o[23], 1);
    step("R7 drop", 8'h01, 0, 0, 0);
    chk("R7 follows", rdata_o[23], 0);
    // R8 inhibited sources
    step("R8 int lvl0", 8'h41, 0, 0, 0);
    chk("R8 int inhibited", rdata_o[27], 0);
    step("R8 ext lvl0", 8'h43, 0, 0, 0);
    chk("R8 ext inhibited", rdata_o[7], 0);
    // R9 ties and maximum
    step("R9 set", 8'h01, 1, 1, 32'h000C_0C00);
    step("R9 tie", 8'h15, 0, 0, 0);
    chk("R9 tie high idx", {26'd0, irq_lvl_o, irq_src_o}, {26'd0, 3'd4, 3'd4});
    step("R9 src7", 8'h95, 1, 1, 32'hC000_0000);
    step("R9 src7 req", 8'h95, 0, 0, 0);
    chk("R9 top nibble", {26'd0, irq_lvl_o, irq_src_o}, {26'd0, 3'd4, 3'd7});
    step("R9 src3 lvl6", 8'h95, 1, 1, 32'h0000_E000);
    step("R9 src3 low", 8'h95, 0, 0, 0);
    step("R9 src3 rise", 8'h9D, 0, 0, 0);
    chk("R9 max", {26'd0, irq_lvl_o, irq_src_o}, {26'd0, 3'd6, 3'd3});

    // random mix of toggles, clears and level updates
    r = req_i;
    for (int n = 0; n < 4000; n++) begin
      r = r ^ 8'($urandom & $urandom);
      step("R9 random", r, ($urandom % 8) != 0, ($urandom % 3) == 0, $urandom);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule